// File: doc/BRIEF.md
# Datapath Debug Statistics and Stage Status Monitor

This block sits next to a streaming processing chain and gives software a way to find a failing stage without an embedded logic analyzer. It watches a row of observation points along the chain. Each point is a valid/ready handshake with a last marker and a byte-keep field. For every point it keeps a packet counter and a byte counter. Software compares neighbouring points: if the counts going into a stage advance but the counts coming out stall or lag, that stage is the suspect.

Each stage between two points also presents its controller's current-state code. The block mirrors that code into a readable register, so software can see whether a quiet stage has returned to its idle encoding or is stuck in some other state. Each stage can be given a one-cycle logic reset from software, separate from the global reset. A small word-addressed read/write bus gives access to all of this. Counters wider than the bus are read coherently: reading the low word also captures the whole value into a shadow register.

The counter width is one parameter shared by all counters. Typical values are 8, 16 or 32 bits. Counters saturate at all-ones.

Top module: `stat_monitor`

## Requirements
- R1: After reset, every counter reads 0, `busRdData` is 0 and `stageRst` is all zeros.
- R2: The packet counter of point p adds one for each clock edge where `ptValid[p]`, `ptReady[p]` and `ptLast[p]` are all high. A beat without last, or a beat whose valid is not matched by ready, is not counted.
- R3: The byte counter of point p adds the number of set bits in `ptKeep[p*KEEP_W +: KEEP_W]` on each accepted beat (valid and ready), whether or not it is last. A keep of zero adds nothing.
- R4: A counter that would pass all-ones stays at all-ones and never wraps. Other counters keep counting normally.
- R5: A write to address 0 with `busWrData[0]`=1 zeroes every counter at that edge. The clear wins over an increment at the same edge. A write to address 0 with bit 0 clear changes nothing.
- R6: A read of address 2+s returns the `STATE_W`-bit state code of stage s, taken from `stState[s*STATE_W +: STATE_W]` and zero-extended to the bus width.
- R7: A write to address 1 drives `stageRst[s]` high for exactly the one cycle after the write edge, for each bit s set in `busWrData`, and then drops it. Address 1 always reads 0.
- R8: Counter k sits at word address 2+NUM_STAGES+k*WORDS+w. Here k=2p is the packet counter of point p and k=2p+1 is its byte counter, and WORDS is CNT_W/DATA_W rounded up. Reading word w=0 returns the live low bits and copies the whole counter into the shadow register. Reading a word w>0 returns bits [w*DATA_W +: DATA_W] of the shadow register, not of the live counter.
- R9: `busRdData` is loaded at the edge where `busRdEn` is high and holds its value while `busRdEn` is low. Reads of address 0 or of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous global reset |
| ptValid | input | NUM_POINTS | Valid of each observation point |
| ptReady | input | NUM_POINTS | Ready of each observation point |
| ptLast | input | NUM_POINTS | Last-beat marker of each point |
| ptKeep | input | NUM_POINTS*KEEP_W | Byte-keep field of each point, point p at [p*KEEP_W +: KEEP_W] |
| stState | input | NUM_STAGES*STATE_W | Current-state code of each stage controller |
| stageRst | output | NUM_STAGES | One-cycle software logic reset per stage |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Word address |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, registered |

## Verification
The bench builds the block with five points, four stages, a 4-bit keep field, an 8-bit bus and 16-bit counters. These values make every counter span two bus words, so the low-word capture and the shadowed high word can be exercised with a carry landing between the two reads. They also keep all-ones within about 65 thousand beats, so both packet and byte counters can be driven into saturation. With a 3-bit state code the mirror width is smaller than the bus, which tests the zero-extension.

// File: rtl/stat_monitor_pkg.sv
package stat_monitor_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATE,
    RD_CNT_LO,
    RD_CNT_HI
  } rdKind_e;

  typedef struct packed {
    logic             clr;
    logic             rdEn;
    rdKind_e          kind;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] word;
  } monStrobe_t;

endpackage

// File: rtl/stat_monitor_satcnt.sv
module stat_monitor_satcnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    sum     = {1'b0, cnt} + (CNT_W+1)'(inc);
    nextCnt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= nextCnt;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '1 && !clr) |=> cnt == '1);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> cnt == '0);

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> cnt >= $past(cnt));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inc != '0 && cnt != '1 && !clr) |=> cnt != $past(cnt));

endmodule

// File: rtl/stat_monitor_ctrl.sv
module stat_monitor_ctrl
  import stat_monitor_pkg::*;
#(
  parameter int NUM_POINTS = 5,
  parameter int NUM_STAGES = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output monStrobe_t            stb,
  output logic [NUM_STAGES-1:0] stageRst
);

  localparam int WORDS    = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int NUM_CNT  = 2 * NUM_POINTS;
  localparam int ADDR_CLR = 0;
  localparam int ADDR_RST = 1;
  localparam int ST_BASE  = 2;
  localparam int CNT_BASE = ST_BASE + NUM_STAGES;
  localparam int CNT_END  = CNT_BASE + NUM_CNT * WORDS;

  int   aInt;
  int   off;
  logic rstWrite;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign rstWrite     = wrEn && (int'(addr) == ADDR_RST);

  always_comb begin
    stb      = '0;
    stb.kind = RD_NONE;
    aInt     = int'(addr);
    off      = 0;
    stb.rdEn = rdEn;
    stb.clr  = wrEn && (aInt == ADDR_CLR) && wrData[0];
    if (aInt >= ST_BASE && aInt < CNT_BASE) begin
      stb.kind = RD_STATE;
      stb.idx  = IDX_W'(aInt - ST_BASE);
    end else if (aInt >= CNT_BASE && aInt < CNT_END) begin
      off      = aInt - CNT_BASE;
      stb.idx  = IDX_W'(off / WORDS);
      stb.word = IDX_W'(off % WORDS);
      stb.kind = ((off % WORDS) == 0) ? RD_CNT_LO : RD_CNT_HI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         stageRst <= '0;
    else if (rstWrite) stageRst <= wrData[NUM_STAGES-1:0];
    else               stageRst <= '0;
  end

  // R7
  rst_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stageRst && !rstWrite) |=> stageRst == '0);

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rstWrite |=> stageRst == '0);

endmodule

// File: rtl/stat_monitor_dp.sv
module stat_monitor_dp
  import stat_monitor_pkg::*;
#(
  parameter int NUM_POINTS = 5,
  parameter int NUM_STAGES = 4,
  parameter int KEEP_W     = 4,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 16,
  parameter int STATE_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  monStrobe_t                    stb,
  input  logic [NUM_POINTS-1:0]         ptValid,
  input  logic [NUM_POINTS-1:0]         ptReady,
  input  logic [NUM_POINTS-1:0]         ptLast,
  input  logic [NUM_POINTS*KEEP_W-1:0]  ptKeep,
  input  logic [NUM_STAGES*STATE_W-1:0] stState,
  output logic [DATA_W-1:0]             rdData
);

  localparam int WORDS   = (CNT_W + DATA_W - 1) / DATA_W;
  localparam int WIDE_W  = WORDS * DATA_W;
  localparam int NUM_CNT = 2 * NUM_POINTS;
  localparam int BINC_W  = $clog2(KEEP_W + 1);

  logic [CNT_W-1:0]  cntVal [NUM_CNT];
  logic [WIDE_W-1:0] shadow;
  logic [WIDE_W-1:0] selWide;
  logic [DATA_W-1:0] stSel;

  for (genvar p = 0; p < NUM_POINTS; p++) begin : g_point
    logic              accept;
    logic [0:0]        pktInc;
    logic [BINC_W-1:0] byteInc;

    assign accept = ptValid[p] && ptReady[p];
    assign pktInc = accept && ptLast[p];

    always_comb begin
      byteInc = '0;
      for (int b = 0; b < KEEP_W; b++) begin
        if (accept && ptKeep[p*KEEP_W + b]) byteInc = byteInc + 1'b1;
      end
    end

    stat_monitor_satcnt #(.CNT_W(CNT_W), .INC_W(1)) u_pkt (
      .clk(clk), .rstN(rstN), .clr(stb.clr), .inc(pktInc), .cnt(cntVal[2*p])
    );

    stat_monitor_satcnt #(.CNT_W(CNT_W), .INC_W(BINC_W)) u_byte (
      .clk(clk), .rstN(rstN), .clr(stb.clr), .inc(byteInc), .cnt(cntVal[2*p+1])
    );
  end

  always_comb begin
    selWide = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (IDX_W'(k) == stb.idx) selWide = WIDE_W'(cntVal[k]);
    end
    stSel = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (IDX_W'(s) == stb.idx) stSel = DATA_W'(stState[s*STATE_W +: STATE_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      shadow <= '0;
    end else if (stb.rdEn) begin
      case (stb.kind)
        RD_STATE:  rdData <= stSel;
        RD_CNT_LO: begin
          rdData <= selWide[DATA_W-1:0];
          shadow <= selWide;
        end
        RD_CNT_HI: rdData <= shadow[stb.word*DATA_W +: DATA_W];
        default:   rdData <= '0;
      endcase
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdEn && stb.kind == RD_CNT_LO) |=> $stable(shadow));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/stat_monitor.sv
module stat_monitor
  import stat_monitor_pkg::*;
#(
  parameter int NUM_POINTS = 5,
  parameter int NUM_STAGES = 4,
  parameter int KEEP_W     = 4,
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 16,
  parameter int STATE_W    = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_POINTS-1:0]         ptValid,
  input  logic [NUM_POINTS-1:0]         ptReady,
  input  logic [NUM_POINTS-1:0]         ptLast,
  input  logic [NUM_POINTS*KEEP_W-1:0]  ptKeep,
  input  logic [NUM_STAGES*STATE_W-1:0] stState,
  output logic [NUM_STAGES-1:0]         stageRst,
  input  logic                          busWrEn,
  input  logic                          busRdEn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData
);

  monStrobe_t stb;

  stat_monitor_ctrl #(
    .NUM_POINTS(NUM_POINTS), .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .stb(stb), .stageRst(stageRst)
  );

  stat_monitor_dp #(
    .NUM_POINTS(NUM_POINTS), .NUM_STAGES(NUM_STAGES), .KEEP_W(KEEP_W),
    .CNT_W(CNT_W), .DATA_W(DATA_W), .STATE_W(STATE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ptValid(ptValid), .ptReady(ptReady),
    .ptLast(ptLast), .ptKeep(ptKeep), .stState(stState), .rdData(busRdData)
  );

endmodule

// File: tb/stat_monitor_bench.sv
module stat_monitor_bench;

  localparam int NP = 5;
  localparam int NS = 4;
  localparam int KW = 4;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int SW = 3;
  localparam int AW = 6;
  localparam int CBASE = 2 + NS;
  localparam int SATV = 65535;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] ptValid = '0;
  logic [NP-1:0] ptReady = '0;
  logic [NP-1:0] ptLast = '0;
  logic [NP*KW-1:0] ptKeep = '0;
  logic [NS*SW-1:0] stState = '0;
  logic [NS-1:0] stageRst;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;

  stat_monitor #(
    .NUM_POINTS(NP), .NUM_STAGES(NS), .KEEP_W(KW), .CNT_W(CW),
    .DATA_W(DW), .STATE_W(SW), .ADDR_W(AW)
  ) u_stat_monitor (
    .clk(clk), .rstN(rstN), .ptValid(ptValid), .ptReady(ptReady),
    .ptLast(ptLast), .ptKeep(ptKeep), .stState(stState), .stageRst(stageRst),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  always #10 clk = ~clk;

  int    nChecks = 0;
  int    nFails = 0;
  int    expPkt [NP];
  int    expByte [NP];
  int    expQ [$];
  string tagQ [$];
  logic  rdFired = 1'b0;
  bit    finished = 1'b0;

  always @(posedge clk) rdFired <= busRdEn;

  // monitor: compare each registered read result with the queued expectation
  always @(negedge clk) begin
    if (rdFired) begin
      int    e;
      string t;
      if (expQ.size() == 0) begin
        e = -1;
        t = "R9 unexpected read";
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
      end
      nChecks++;
      if (e < 0 || busRdData !== DW'(e)) begin
        nFails++;
        $display("FAIL %s: rdData=%0h expected %0h", t, busRdData, e);
      end
    end
  end

  task automatic check(input string t, input int act, input int e);
    nChecks++;
    if (act != e) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected %0h", t, act, e);
    end
  endtask

  task automatic busRead(input int a, input int e, input string t);
    busAddr = AW'(a);
    busRdEn = 1'b1;
    expQ.push_back(e & 8'hFF);
    tagQ.push_back(t);
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic busWrite(input int a, input int d);
    busAddr   = AW'(a);
    busWrData = DW'(d);
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  function automatic int cAddr(input int p, input int isByte, input int w);
    return CBASE + (2 * p + isByte) * 2 + w;
  endfunction

  task automatic readCnt(input int p, input int isByte, input string t);
    int e;
    e = isByte ? expByte[p] : expPkt[p];
    busRead(cAddr(p, isByte, 0), e, t);
    busRead(cAddr(p, isByte, 1), e >> 8, t);
  endtask

  function automatic int popc(input logic [KW-1:0] k);
    int n = 0;
    for (int i = 0; i < KW; i++) n += int'(k[i]);
    return n;
  endfunction

  task automatic stream(input int p, input int n, input bit rdy, input bit lst,
                        input logic [KW-1:0] kp);
    ptValid[p] = 1'b1;
    ptReady[p] = rdy;
    ptLast[p]  = lst;
    ptKeep[p*KW +: KW] = kp;
    repeat (n) @(posedge clk);
    @(negedge clk);
    ptValid[p] = 1'b0;
    ptReady[p] = 1'b0;
    ptLast[p]  = 1'b0;
    ptKeep[p*KW +: KW] = '0;
    if (rdy) begin
      expByte[p] += n * popc(kp);
      if (lst) expPkt[p] += n;
      if (expByte[p] > SATV) expByte[p] = SATV;
      if (expPkt[p] > SATV) expPkt[p] = SATV;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      expPkt[p]  = 0;
      expByte[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 stageRst in reset", int'(stageRst), 0);
    check("R1 rdData in reset", int'(busRdData), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: counters start at zero
    readCnt(0, 0, "R1 pkt0 after reset");
    readCnt(4, 1, "R1 byte4 after reset");
    busRead(0, 0, "R9 ctrl address reads 0");

    // R2/R3: basic counting with mixed last/keep/ready
    stream(0, 1, 1'b1, 1'b0, 4'b1111);
    stream(0, 1, 1'b1, 1'b0, 4'b1111);
    stream(0, 1, 1'b1, 1'b1, 4'b1111);
    stream(0, 3, 1'b0, 1'b1, 4'b1111);
    readCnt(0, 0, "R2 pkt0 last-only counting");
    readCnt(0, 1, "R3 byte0 keep sum");
    stream(2, 2, 1'b1, 1'b1, 4'b0101);
    stream(2, 1, 1'b1, 1'b1, 4'b0000);
    stream(2, 1, 1'b1, 1'b0, 4'b1000);
    readCnt(2, 0, "R2 pkt2 count");
    readCnt(2, 1, "R3 byte2 partial keep");
    readCnt(1, 0, "R2 pkt1 untouched");

    // R8: shadow coherency across a carry between word reads
    stream(1, 63, 1'b1, 1'b0, 4'b1111);
    busRead(cAddr(1, 1, 0), 8'hFC, "R8 byte1 low 0xFC");
    stream(1, 1, 1'b1, 1'b0, 4'b1111);
    busRead(cAddr(1, 1, 1), 8'h00, "R8 byte1 high from shadow");
    readCnt(1, 1, "R8 byte1 fresh 0x100");

    // R6: state mirror
    stState = {3'd2, 3'd7, 3'd5, 3'd0};
    busRead(2, 0, "R6 stage0 idle");
    busRead(3, 5, "R6 stage1 state");
    busRead(4, 7, "R6 stage2 state");
    busRead(5, 2, "R6 stage3 state");
    stState[SW +: SW] = 3'd0;
    busRead(3, 0, "R6 stage1 back to idle");

    // R7: soft reset pulse
    busAddr   = AW'(1);
    busWrData = 8'h05;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    check("R7 stageRst pulse", int'(stageRst), 5);
    @(negedge clk);
    check("R7 stageRst drops", int'(stageRst), 0);
    busRead(1, 0, "R7 reset register reads 0");

    // R5: clear control
    busWrite(0, 8'hFE);
    readCnt(0, 1, "R5 write without bit0 no effect");
    busAddr   = AW'(0);
    busWrData = 8'h01;
    busWrEn   = 1'b1;
    ptValid[0] = 1'b1;
    ptReady[0] = 1'b1;
    ptLast[0]  = 1'b1;
    ptKeep[0 +: KW] = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    ptValid[0] = 1'b0;
    ptReady[0] = 1'b0;
    ptLast[0]  = 1'b0;
    ptKeep[0 +: KW] = '0;
    for (int p = 0; p < NP; p++) begin
      expPkt[p]  = 0;
      expByte[p] = 0;
    end
    readCnt(0, 0, "R5 clear beats coincident pkt");
    readCnt(0, 1, "R5 clear beats coincident bytes");
    readCnt(1, 1, "R5 clear zeroes byte1");

    // R4: saturation
    stream(4, 16400, 1'b1, 1'b0, 4'b1111);
    readCnt(4, 1, "R4 byte4 saturated");
    readCnt(4, 0, "R4 pkt4 still zero");
    stream(3, 65540, 1'b1, 1'b1, 4'b0001);
    readCnt(3, 0, "R4 pkt3 saturated");
    readCnt(3, 1, "R4 byte3 saturated");

    // R9: unmapped address and hold
    busRead(60, 0, "R9 unmapped reads 0");
    repeat (3) @(negedge clk);
    check("R9 rdData held", int'(busRdData), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule